// File: doc/BRIEF.md
# Montgomery Modular Multiply-Add Unit

This unit computes `(a*b + c) mod q` for one coefficient at a time, walking a vector of `N_ELEM` coefficients one element per handshake. The modulus `q` is an odd value of up to `W` bits. All modular reduction is done by Montgomery reduction with radix `R = 2^W`, so the datapath never performs a trial division.

Each accepted element goes through a fixed sequence of steps on a single shared reduction unit:
1. The three operands are moved into Montgomery form by reducing each against `R^2 mod q`.
2. The two mapped factors are multiplied and reduced.
3. The mapped addend is added modulo `q`.
4. One final reduction against the constant 1 returns the sum to ordinary form.

The caller supplies `q`, `q' = -q^-1 mod R` and `R^2 mod q` as precomputed, quasi-static inputs. These must not change while an element is in flight.

The input and the output each use a valid/ready handshake. An element counter flags the last result of each vector and then starts a new vector.

Top module: `mont_mac`

## Requirements
- R1: For operands a, b, c each below q, the result on `out_data_o` equals (a*b + c) mod q and is always below q.
- R2: `in_ready_o` is high only while the unit is idle. An element offered while the unit is busy is not taken and does not disturb the result in flight. `in_ready_o` and `out_valid_o` are never high together.
- R3: `out_valid_o` rises exactly 6 clock cycles after the clock edge that accepts an element.
- R4: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` stays unchanged.
- R5: `out_last_o` is high together with `out_valid_o` on the N_ELEM-th result of a vector, and on no other result. After that result is taken, the next result counts as the first of a new vector. `out_last_o` is never high without `out_valid_o`.
- R6: While `rst_ni` is low, `in_ready_o` is 1, `out_valid_o` is 0 and `out_last_o` is 0. Reset also restarts the element count.
- R7: The result is correct for any odd q below 2^W, including very small moduli (q = 3) and moduli close to 2^W. This includes the extreme operands 0 and q-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q_i | input | W | Odd modulus, below 2^W |
| qinv_i | input | W | -q^-1 mod 2^W |
| r2_i | input | W | 2^(2W) mod q |
| in_valid_i | input | 1 | Operand triple offered |
| in_ready_o | output | 1 | Unit idle and accepting |
| a_i | input | W | First factor, below q |
| b_i | input | W | Second factor, below q |
| c_i | input | W | Addend, below q |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer takes result |
| out_data_o | output | W | (a*b + c) mod q |
| out_last_o | output | 1 | Result is the last of a vector |

## Verification
A result is due exactly six rising edges after the edge that accepts its element. It then stays on the port until the consumer takes it. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the accepting edge and checks that `out_valid_o` first appears on the sixth. It then compares data and the last flag against a wide-integer model, both at the first valid cycle and again after an imposed stall. Busy-time offers and `in_ready_o` are checked in the cycles between acceptance and result.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TA,    // a -> Montgomery form
    ST_TB,    // b -> Montgomery form
    ST_TC,    // c -> Montgomery form
    ST_MUL,   // aM*bM reduced
    ST_ADD,   // + cM mod q
    ST_EXIT,  // back to normal form
    ST_RESP
  } mont_st_e;
endpackage

// File: rtl/mont_redc.sv
// Combinational Montgomery reduction of x*y: returns x*y*R^-1 mod q, R = 2^W.
module mont_redc #(
  parameter int W = 64
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] qinv_i,
  output logic [W-1:0] r_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  logic [W-1:0]  m;
  logic [PW:0]   acc;
  logic [W:0]    t_sh;

  assign prod = PW'(x_i) * PW'(y_i);
  // wraps at W bits: m = (prod mod R) * q' mod R
  assign m    = prod[W-1:0] * qinv_i;
  assign acc  = (PW+1)'(prod) + (PW+1)'(PW'(m) * PW'(q_i));
  assign t_sh = (W+1)'(acc >> W);
  assign r_o  = (t_sh >= {1'b0, q_i}) ? W'(t_sh - {1'b0, q_i}) : W'(t_sh);
endmodule

// File: rtl/mont_modadd.sv
module mont_modadd #(
  parameter int W = 64
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] q_i,
  output logic [W-1:0] r_o
);
  logic [W:0] sum;

  assign sum = {1'b0, x_i} + {1'b0, y_i};
  assign r_o = (sum >= {1'b0, q_i}) ? W'(sum - {1'b0, q_i}) : W'(sum);
endmodule

// File: rtl/mont_elem_ctr.sv
module mont_elem_ctr #(
  parameter int N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic last_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/mont_mac.sv
module mont_mac
  import mont_pkg::*;
#(
  parameter int W      = 64,
  parameter int N_ELEM = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] qinv_i,
  input  logic [W-1:0] r2_i,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o,
  output logic         out_last_o
);
  mont_st_e     st_q;
  logic [W-1:0] a_q, b_q, c_q;
  logic [W-1:0] red_x, red_y, red_r, add_r;
  logic         ctr_last, out_hs, in_hs;

  assign in_ready_o  = (st_q == ST_IDLE);
  assign out_valid_o = (st_q == ST_RESP);
  assign in_hs       = in_valid_i && in_ready_o;
  assign out_hs      = out_valid_o && out_ready_i;
  assign out_data_o  = a_q;
  assign out_last_o  = out_valid_o && ctr_last;

  // Shared reduction unit: operand pair selected by step
  always_comb begin
    red_x = a_q;
    red_y = r2_i;
    unique case (st_q)
      ST_TB:   red_x = b_q;
      ST_TC:   red_x = c_q;
      ST_MUL:  red_y = b_q;
      ST_EXIT: red_y = W'(1);
      default: ;
    endcase
  end

  mont_redc #(.W(W)) u_redc (
    .x_i(red_x), .y_i(red_y), .q_i(q_i), .qinv_i(qinv_i), .r_o(red_r)
  );

  mont_modadd #(.W(W)) u_add (
    .x_i(a_q), .y_i(c_q), .q_i(q_i), .r_o(add_r)
  );

  mont_elem_ctr #(.N(N_ELEM)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(out_hs), .last_o(ctr_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      a_q  <= '0;
      b_q  <= '0;
      c_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (in_hs) begin
          a_q  <= a_i;
          b_q  <= b_i;
          c_q  <= c_i;
          st_q <= ST_TA;
        end
        ST_TA:   begin a_q <= red_r; st_q <= ST_TB;   end
        ST_TB:   begin b_q <= red_r; st_q <= ST_TC;   end
        ST_TC:   begin c_q <= red_r; st_q <= ST_MUL;  end
        ST_MUL:  begin a_q <= red_r; st_q <= ST_ADD;  end
        ST_ADD:  begin a_q <= add_r; st_q <= ST_EXIT; end
        ST_EXIT: begin a_q <= red_r; st_q <= ST_RESP; end
        ST_RESP: if (out_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mont_mac_chk.sv
module mont_mac_chk #(
  parameter int W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] q_i,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic         out_valid_o,
  input logic         out_ready_i,
  input logic [W-1:0] out_data_o,
  input logic         out_last_o
);
  logic [2:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       lat_q <= 3'd7;
    else if (in_valid_i && in_ready_o) lat_q <= 3'd0;
    else if (lat_q != 3'd7)            lat_q <= lat_q + 3'd1;
  end

  // R1
  result_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_data_o < q_i));

  // R2
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  // R3
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> (lat_q == 3'd6));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  // R5
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);
endmodule

bind mont_mac mont_mac_chk #(.W(W)) u_mont_mac_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .q_i(q_i),
  .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_data_o(out_data_o), .out_last_o(out_last_o)
);

// File: tb/mont_mac_bench.sv
`timescale 1ns/1ps
module mont_mac_bench;
  localparam int W = 64;
  localparam int N = 8;
  localparam logic [63:0] Q0 = 64'h1FFF_FFFF_FFFF_FFFF;  // 2^61-1
  localparam logic [63:0] QBIG = 64'hFFFF_FFFF_FFFF_FFC5; // 2^64-59
  localparam logic [63:0] TBL [8][3] = '{
    '{64'd0, 64'd0, 64'd0},
    '{64'd1, 64'd1, 64'd0},
    '{64'd123456789, 64'd987654321, 64'd555},
    '{Q0 - 64'd1, Q0 - 64'd1, Q0 - 64'd1},
    '{64'h0123_4567_89AB_CDE0, 64'h0FED_CBA9_8765_4321, 64'h1111_1111_1111_1111},
    '{64'd2, 64'h1000_0000_0000_0000, 64'd7},
    '{64'h1ABC_DEF0_1234_5678, 64'd3, 64'd0},
    '{64'd1, 64'd0, Q0 - 64'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] q_in, qinv_in, r2_in, a_in, b_in, c_in;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_last;
  logic [W-1:0] out_data;
  int checks = 0, fails = 0, pos = 0;

  always #2.5 clk = ~clk;

  mont_mac #(.W(W), .N_ELEM(N)) u_mont_mac (
    .clk_i(clk), .rst_ni(rst_n), .q_i(q_in), .qinv_i(qinv_in), .r2_i(r2_in),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .a_i(a_in), .b_i(b_in), .c_i(c_in),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_last_o(out_last)
  );

  function automatic logic [63:0] model(input logic [63:0] a, b, c, q);
    logic [127:0] p;
    p = {64'd0, a} * {64'd0, b} + {64'd0, c};
    return 64'(p % {64'd0, q});
  endfunction

  task automatic set_mod(input logic [63:0] q);
    logic [63:0] inv;
    logic [128:0] big;
    inv = q;
    for (int i = 0; i < 6; i++) inv = inv * (64'd2 - q * inv);
    big = 129'd1 << 128;
    q_in = q;
    qinv_in = -inv;
    r2_in = 64'(big % {65'd0, q});
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_elem(input logic [63:0] a, b, c, input int stall,
                          input bit busy, input string req);
    logic [63:0] exp;
    bit exp_last;
    int k;
    exp = model(a, b, c, q_in);
    exp_last = (pos == N - 1);
    @(negedge clk);
    in_valid = 1'b1; a_in = a; b_in = b; c_in = c;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    k = 0;
    while (!out_valid && k < 40) begin
      if (busy && k == 1) begin
        in_valid = 1'b1; a_in = ~a; b_in = ~b; c_in = ~c;
      end
      if (busy && k == 3) chk(!in_ready, "R2 busy ready", 64'(in_ready), 64'd0);
      @(negedge clk);
      k++;
    end
    in_valid = 1'b0;
    chk(k == 6, "R3 latency", 64'(k), 64'd6);
    chk(out_data == exp, req, out_data, exp);
    chk(out_last == exp_last, "R5 last flag", 64'(out_last), 64'(exp_last));
    if (stall > 0) begin
      for (int s = 0; s < stall; s++) @(negedge clk);
      chk(out_valid && out_data == exp, "R4 hold under stall", out_data, exp);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready && !out_valid, "R2 idle after take", 64'(in_ready), 64'd1);
    pos = (pos + 1) % N;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] ra, rb, rc;
    set_mod(Q0);
    a_in = '0; b_in = '0; c_in = '0;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk(in_ready && !out_valid && !out_last, "R6 reset outputs",
        {61'd0, in_ready, out_valid, out_last}, 64'd4);
    rst_n = 1'b1;

    // R1 table walk, one full vector (R5 last on element 8)
    for (int i = 0; i < 8; i++) run_elem(TBL[i][0], TBL[i][1], TBL[i][2], 0, 1'b0, "R1 table");

    // R1 random operands below q
    for (int i = 0; i < 8; i++) begin
      ra = {$urandom, $urandom} % Q0;
      rb = {$urandom, $urandom} % Q0;
      rc = {$urandom, $urandom} % Q0;
      run_elem(ra, rb, rc, 0, 1'b0, "R1 random");
    end

    // R4 stall, R2 busy offer ignored
    run_elem(64'h0ABC_DEF1_2345_6789, 64'h1234_5678_9ABC_DEF0, 64'd99, 4, 1'b0, "R4 stall data");
    run_elem(64'd777, 64'd888, 64'd999, 0, 1'b1, "R2 busy data");

    // R7 small and near-full moduli
    set_mod(64'd3);
    run_elem(64'd2, 64'd2, 64'd2, 0, 1'b0, "R7 q=3 max");
    run_elem(64'd2, 64'd1, 64'd0, 0, 1'b0, "R7 q=3 mid");
    set_mod(QBIG);
    run_elem(QBIG - 64'd1, QBIG - 64'd1, 64'd5, 0, 1'b0, "R7 big q-1 sq");
    run_elem(QBIG - 64'd1, 64'd2, 64'd0, 0, 1'b0, "R7 big q-2");
    run_elem(64'd0, QBIG - 64'd1, QBIG - 64'd1, 2, 1'b0, "R7 big zero");

    // R6 mid-vector reset restarts count
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(in_ready && !out_valid && !out_last, "R6 reset mid-vector",
        {61'd0, in_ready, out_valid, out_last}, 64'd4);
    rst_n = 1'b1;
    pos = 0;
    set_mod(Q0);
    for (int i = 0; i < N; i++) run_elem(TBL[7 - i][0], TBL[7 - i][1], TBL[7 - i][2], 0, 1'b0, "R5 vector after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule